// File: doc/BRIEF.md
# DMA Channel Request Enable Gate

This block keeps one enable bit per DMA channel for 64 channels and uses it to qualify the hardware service requests that peripherals raise. The bits are reached in two ways. Software can read or replace a whole 32-channel half in one write: the upper half covers channels 63 to 32 and the lower half covers channels 31 to 0. Software can also send a short command on a dedicated set port or clear port. Such a command changes one channel, or every channel, and leaves the rest alone, so no read-modify-write is needed.

The qualified request vector is registered. A hardware request for a channel reaches the output only while that channel's enable bit is 1. Software-initiated requests and requests raised by channel linking always pass, whatever the enable bit holds. The arbiter that follows sees one merged request bit per channel.

Top module: `dma_req_gate`

## Requirements
- R1: While rst_n is low, every enable bit and every bit of req_out is 0 at the next clock edge, even if requests are driven.
- R2: A lower-half write (lo_wr=1) replaces channels 31..0 with lo_wdata, where data bit k holds channel k. rd_lo_data reads those channels back in the same bit order.
- R3: An upper-half write (hi_wr=1) replaces channels 63..32 with hi_wdata, where data bit k holds channel 32+k, so bit 31 holds channel 63. rd_hi_data reads them back in the same order.
- R4: A set command (set_wr=1, bit 7 = 0, bit 6 = 0) sets the enable of the channel named by bits [5:0] and leaves the other channels unchanged.
- R5: A set or clear command with bit 7 = 0 and bit 6 = 1 acts on all 64 channels and ignores bits [5:0].
- R6: A command with bit 7 = 1 changes no enable bit. With no write of any kind, the enable state is held.
- R7: A clear command (clr_wr=1, bit 7 = 0, bit 6 = 0) clears the enable of the channel named by bits [5:0] and leaves the other channels unchanged.
- R8: Writes in the same cycle apply in this order: half-word writes first, then set, then clear. If set and clear name the same channel, clear wins.
- R9: req_out bit c is 1 after an edge when hw_req[c] was 1 at that edge and channel c was enabled before that edge.
- R10: sw_req[c] or link_req[c] at an edge sets req_out bit c after that edge, whatever the enable bit holds.
- R11: req_out is registered. An enable change made at an edge first affects req_out at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_wr | input | 1 | Write strobe for the upper half (channels 63..32) |
| hi_wdata | input | 32 | Upper-half write data, bit k = channel 32+k |
| lo_wr | input | 1 | Write strobe for the lower half (channels 31..0) |
| lo_wdata | input | 32 | Lower-half write data, bit k = channel k |
| set_wr | input | 1 | Set-command strobe |
| set_cmd | input | 8 | Set command: [7] no-op, [6] all channels, [5:0] channel |
| clr_wr | input | 1 | Clear-command strobe |
| clr_cmd | input | 8 | Clear command: [7] no-op, [6] all channels, [5:0] channel |
| hw_req | input | 64 | Hardware service requests, one per channel |
| sw_req | input | 64 | Software-initiated requests, one per channel |
| link_req | input | 64 | Channel-linked requests, one per channel |
| rd_hi_data | output | 32 | Current enables of channels 63..32 |
| rd_lo_data | output | 32 | Current enables of channels 31..0 |
| req_out | output | 64 | Registered qualified request vector |

## Verification
A half-word write and a set or clear command can land on the enable state in the same cycle. A set and a clear can also name the same channel in that cycle. Directed cycles provoke both cases: a full lower-half write of ones with a clear of channel 3, an upper-half write of zeros with a set of channel 40, and a set and a clear of channel 10 together. Long runs of random cycles also mix all three write paths freely. The bench judges every result against a reference model that applies the half-word write, then the set, then the clear. It compares both read ports and req_out with that model after every edge.

// File: rtl/dma_req_gate_pkg.sv
// Package: shared constants for the request enable gate.
// Assumes: the set and clear commands are 8 bits wide, which covers up to 64 channels.
package dma_req_gate_pkg;
    localparam int CMD_W       = 8;
    localparam int CMD_NOP_BIT = 7;
    localparam int CMD_ALL_BIT = 6;
endpackage

// File: rtl/req_en_cmd_decode.sv
// Module: turns one set or clear command into a per-channel mask.
// Assumes: NUM_CH <= 64, so the channel index fits in the command's low bits.
module req_en_cmd_decode #(
    parameter int NUM_CH = 64
) (
    input  logic                               valid,
    input  logic [dma_req_gate_pkg::CMD_W-1:0] cmd,
    output logic [NUM_CH-1:0]                  mask
);
    import dma_req_gate_pkg::*;
    localparam int IDX_W = $clog2(NUM_CH);

    logic active;
    // The command counts only when it is strobed and is not a no-op.
    assign active = valid && !cmd[CMD_NOP_BIT];

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            // Select this channel when it is named, or when all channels are meant.
            assign mask[ch] = active &&
                (cmd[CMD_ALL_BIT] || (cmd[IDX_W-1:0] == IDX_W'(ch)));
        end
    endgenerate
endmodule

// File: rtl/req_en_bitmap.sv
// Module: per-channel enable register with half-word writes and set/clear masks.
// Assumes: NUM_CH is a multiple of WORD_W. Each cycle applies word writes, then set, then clear.
module req_en_bitmap #(
    parameter int NUM_CH = 64,
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH/WORD_W-1:0]       word_wr,
    input  logic [NUM_CH-1:0]              word_wdata,
    input  logic [NUM_CH-1:0]              set_mask,
    input  logic [NUM_CH-1:0]              clr_mask,
    output logic [NUM_CH-1:0]              en
);
    localparam int NWORDS = NUM_CH / WORD_W;

    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] word_stage;
    logic [NUM_CH-1:0] en_next;

    genvar w;
    generate
        for (w = 0; w < NWORDS; w++) begin : g_word
            // A full-word write replaces its half; otherwise the half keeps its value.
            assign word_stage[w*WORD_W +: WORD_W] =
                word_wr[w] ? word_wdata[w*WORD_W +: WORD_W] : en_q[w*WORD_W +: WORD_W];
        end
    endgenerate

    // Set after the word writes, then clear, so clear has the last word.
    assign en_next = (word_stage | set_mask) & ~clr_mask;

    // Enable state register.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_next;
    end

    assign en = en_q;
endmodule

// File: rtl/req_qualify.sv
// Module: gates hardware requests with the enables and merges bypass requests.
// Assumes: en is the registered enable state; the output is registered.
module req_qualify #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] link_req,
    output logic [NUM_CH-1:0] req_q
);
    logic [NUM_CH-1:0] merged;

    // Only hardware requests depend on the enable; software and linked requests pass.
    assign merged = (hw_req & en) | sw_req | link_req;

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= merged;
    end
endmodule

// File: rtl/dma_req_gate.sv
// Module: top of the DMA channel request enable gate.
// Assumes: two halves of WORD_W channels each; synchronous active-low reset.
module dma_req_gate #(
    parameter int WORD_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               hi_wr,
    input  logic [WORD_W-1:0]                  hi_wdata,
    input  logic                               lo_wr,
    input  logic [WORD_W-1:0]                  lo_wdata,
    input  logic                               set_wr,
    input  logic [dma_req_gate_pkg::CMD_W-1:0] set_cmd,
    input  logic                               clr_wr,
    input  logic [dma_req_gate_pkg::CMD_W-1:0] clr_cmd,
    input  logic [2*WORD_W-1:0]                hw_req,
    input  logic [2*WORD_W-1:0]                sw_req,
    input  logic [2*WORD_W-1:0]                link_req,
    output logic [WORD_W-1:0]                  rd_hi_data,
    output logic [WORD_W-1:0]                  rd_lo_data,
    output logic [2*WORD_W-1:0]                req_out
);
    localparam int NUM_CH = 2 * WORD_W;

    logic [NUM_CH-1:0] set_mask;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] en_bits;

    req_en_cmd_decode #(.NUM_CH(NUM_CH)) set_dec_i (
        .valid (set_wr),
        .cmd   (set_cmd),
        .mask  (set_mask)
    );

    req_en_cmd_decode #(.NUM_CH(NUM_CH)) clr_dec_i (
        .valid (clr_wr),
        .cmd   (clr_cmd),
        .mask  (clr_mask)
    );

    req_en_bitmap #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) bitmap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_wr    ({hi_wr, lo_wr}),
        .word_wdata ({hi_wdata, lo_wdata}),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .en         (en_bits)
    );

    req_qualify #(.NUM_CH(NUM_CH)) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_bits),
        .hw_req   (hw_req),
        .sw_req   (sw_req),
        .link_req (link_req),
        .req_q    (req_out)
    );

    // Read ports show the enable state directly.
    assign rd_hi_data = en_bits[NUM_CH-1:WORD_W];
    assign rd_lo_data = en_bits[WORD_W-1:0];
endmodule

// File: rtl/dma_req_gate_chk.sv
// Module: assertion checker for dma_req_gate, attached by bind.
// Assumes: it observes the top-level ports only.
module dma_req_gate_chk #(
    parameter int WORD_W = 32
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               hi_wr,
    input logic [WORD_W-1:0]                  hi_wdata,
    input logic                               lo_wr,
    input logic [WORD_W-1:0]                  lo_wdata,
    input logic                               set_wr,
    input logic [dma_req_gate_pkg::CMD_W-1:0] set_cmd,
    input logic                               clr_wr,
    input logic [dma_req_gate_pkg::CMD_W-1:0] clr_cmd,
    input logic [2*WORD_W-1:0]                hw_req,
    input logic [2*WORD_W-1:0]                sw_req,
    input logic [2*WORD_W-1:0]                link_req,
    input logic [WORD_W-1:0]                  rd_hi_data,
    input logic [WORD_W-1:0]                  rd_lo_data,
    input logic [2*WORD_W-1:0]                req_out
);
    localparam int NUM_CH = 2 * WORD_W;
    localparam int IDX_W  = $clog2(NUM_CH);

    logic [NUM_CH-1:0] en_view;
    logic [NUM_CH-1:0] bypass;
    logic set_one, clr_one, clr_all, set_any, clr_any, clr_hits_set;

    assign en_view      = {rd_hi_data, rd_lo_data};
    assign bypass       = sw_req | link_req;
    assign set_any      = set_wr && !set_cmd[7];
    assign clr_any      = clr_wr && !clr_cmd[7];
    assign set_one      = set_any && !set_cmd[6];
    assign clr_one      = clr_any && !clr_cmd[6];
    assign clr_all      = clr_any && clr_cmd[6];
    assign clr_hits_set = clr_any && (clr_cmd[6] || clr_cmd[IDX_W-1:0] == set_cmd[IDX_W-1:0]);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (en_view == '0 && req_out == '0));

    assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !set_any && !clr_any) |=> rd_lo_data == $past(lo_wdata));

    assert_hi_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !set_any && !clr_any) |=> rd_hi_data == $past(hi_wdata));

    assert_set_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_one && !clr_hits_set) |=> en_view[$past(set_cmd[IDX_W-1:0])]);

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> en_view == '0);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_wr && !lo_wr && !set_any && !clr_any) |=> $stable(en_view));

    assert_clear_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_one |=> !en_view[$past(clr_cmd[IDX_W-1:0])]);

    assert_hw_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_out & ~$past(bypass)) == ($past(hw_req) & $past(en_view) & ~$past(bypass)));

    assert_bypass_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_out & $past(bypass)) == $past(bypass));
endmodule

bind dma_req_gate dma_req_gate_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/dma_req_gate_tb_top.sv
module dma_req_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_wr = 1'b0, lo_wr = 1'b0, set_wr = 1'b0, clr_wr = 1'b0;
    logic [31:0] hi_wdata = '0, lo_wdata = '0;
    logic [7:0]  set_cmd = '0, clr_cmd = '0;
    logic [63:0] hw_req = '0, sw_req = '0, link_req = '0;
    logic [31:0] rd_hi_data, rd_lo_data;
    logic [63:0] req_out;

    int checks = 0;
    int errors = 0;
    logic [63:0] en_m = '0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_req_gate dut_i (.*);

    function automatic logic [63:0] cmd_mask(input logic v, input logic [7:0] c);
        if (!v || c[7]) return '0;
        if (c[6])       return '1;
        return 64'd1 << c[5:0];
    endfunction

    task automatic check64(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle from a negedge, then check both read ports and req_out at the next negedge.
    task automatic cyc(input logic hw_, input logic [31:0] hd, input logic lw_, input logic [31:0] ld,
                       input logic sv, input logic [7:0] sc, input logic cv, input logic [7:0] cc,
                       input logic [63:0] hr, input logic [63:0] sr, input logic [63:0] lr,
                       input string tag_en, input string tag_rq);
        logic [63:0] nxt;
        logic [63:0] exp_rq;
        hi_wr = hw_; hi_wdata = hd; lo_wr = lw_; lo_wdata = ld;
        set_wr = sv; set_cmd = sc; clr_wr = cv; clr_cmd = cc;
        hw_req = hr; sw_req = sr; link_req = lr;
        exp_rq = (hr & en_m) | sr | lr;
        nxt = en_m;
        if (hw_) nxt[63:32] = hd;
        if (lw_) nxt[31:0]  = ld;
        nxt = (nxt | cmd_mask(sv, sc)) & ~cmd_mask(cv, cc);
        @(negedge clk);
        en_m = nxt;
        check64(tag_en, "enables", {rd_hi_data, rd_lo_data}, en_m);
        check64(tag_rq, "req_out", req_out, exp_rq);
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog: actual timeout expected finish");
        errors++;
        checks++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: requests driven during reset must not appear
        sw_req = '1; hw_req = '1; lo_wr = 1'b1; lo_wdata = '1;
        repeat (3) @(negedge clk);
        check64("R1", "enables in reset", {rd_hi_data, rd_lo_data}, '0);
        check64("R1", "req_out in reset", req_out, '0);
        sw_req = '0; hw_req = '0; lo_wr = 1'b0; lo_wdata = '0;
        rst_n = 1'b1;

        // R2 lower half write, then R3 upper half with R11 latency visible on req_out
        cyc(0, 0, 1, 32'h8000_0001, 0, 0, 0, 0, '0, '0, '0, "R2", "R1");
        cyc(1, 32'h8000_0003, 0, 0, 0, 0, 0, 0, '1, '0, '0, "R3", "R11");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, '1, '0, '0, "R6", "R9");
        // R11: enable ch 4 and request it in the same cycle, then again
        cyc(0, 0, 1, 32'h0000_0010, 0, 0, 0, 0, 64'h10, '0, '0, "R2", "R11");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 64'h10, '0, '0, "R6", "R11");
        // R4 set one, R6 no-op commands
        cyc(0, 0, 0, 0, 1, 8'h05, 0, 0, '0, '0, '0, "R4", "R9");
        cyc(0, 0, 0, 0, 1, 8'h86, 0, 0, '0, '0, '0, "R6", "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 8'hC0, '0, '0, '0, "R6", "R9");
        // R7 clear one
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h3F, '0, '0, '0, "R7", "R9");
        // R5 set all, clear all (index bits ignored)
        cyc(0, 0, 0, 0, 1, 8'h55, 0, 0, '0, '0, '0, "R5", "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h6A, '1, '0, '0, "R5", "R9");
        // R8 same-cycle combinations
        cyc(0, 0, 0, 0, 1, 8'h0A, 1, 8'h0A, '0, '0, '0, "R8", "R9");
        cyc(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 1, 8'h03, '0, '0, '0, "R8", "R9");
        cyc(1, 32'h0, 0, 0, 1, 8'h28, 0, 0, '0, '0, '0, "R8", "R9");
        cyc(0, 0, 0, 0, 1, 8'h40, 1, 8'h11, '0, '0, '0, "R8", "R9");
        // R10 bypass with all enables cleared
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h40, '0, '0, '0, "R5", "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, '1, 64'hF0F0_0000_0000_0001, 64'h8000_0000_0000_0100,
            "R6", "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, '0, '0, '0, "R6", "R10");

        // Random mix of every write path and request source
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] sc, cc;
            sc = 8'($urandom); cc = 8'($urandom);
            sc[7] = ($urandom % 6 == 0); sc[6] = ($urandom % 10 == 0);
            cc[7] = ($urandom % 6 == 0); cc[6] = ($urandom % 14 == 0);
            cyc(($urandom % 5 == 0), $urandom, ($urandom % 5 == 0), $urandom,
                ($urandom % 2 == 0), sc, ($urandom % 2 == 0), cc,
                {$urandom, $urandom}, {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom},
                ($urandom % 4 == 0) ? 64'd1 << ($urandom % 64) : 64'd0,
                "R8", "R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule